// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block is the control state machine inside a DRAM controller that decides when the memory device is placed into one of three low-power states and when it is brought back. The states are precharge-all power-down, self-refresh and deep power-down. The block watches configuration bits, two programmable timeouts, the transaction-buffer-empty flag, an incoming-transaction strobe and a refresh-request strobe. It hands one-cycle entry and exit commands to the command scheduler, which acknowledges each with a done strobe.

Power-down is entered automatically after a programmed stretch of idle cycles, in units of 32 cycles. Refresh requests and traffic take the device out of power-down, and the block re-enters once the idle stretch has elapsed again. Self-refresh and deep power-down are entered once the buffers are empty. Deep power-down exit runs a programmed wait in units of 1024 cycles, then issues the exit command, then requests a full DRAM re-initialization. While the block is inside the deep power-down sequence it tells the queue to hold new commands.

Top module: `lpm_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is low and the block is in the active state.
- R2: A cycle is idle when pd_en=1, buf_empty=1, txn_valid=0 and ref_req=0. After N consecutive idle cycles, where N = max(1, 32*pd_idle_x32), enter_pulse is high in the next cycle with pulse_mode=2'b01. Any non-idle cycle restarts the count from zero.
- R3: In power-down, a ref_req cycle produces an exit_pulse with pulse_mode=2'b01. After that exit is acknowledged, power-down is entered again once a further N idle cycles have elapsed.
- R4: In power-down, a txn_valid cycle produces a power-down exit.
- R5: In power-down, pd_en=0 produces a power-down exit, and no entry follows while pd_en stays 0.
- R6: In the active state, sr_req=1 with buf_empty=1 and txn_valid=0 produces enter_pulse with pulse_mode=2'b10. No entry happens while buf_empty=0. In self-refresh, a txn_valid cycle produces an exit_pulse with pulse_mode=2'b10.
- R7: In the active state, dpd_en=1 with buf_empty=1 and txn_valid=0 produces enter_pulse with pulse_mode=2'b11. No entry happens while buf_empty=0.
- R8: In deep power-down, dpd_en=0 starts a wait of max(1, 1024*dpd_wait_x1024) cycles. An exit_pulse with pulse_mode=2'b11 follows the wait. Once that exit is acknowledged, init_req goes high and stays high until init_done is sampled, after which the block is active.
- R9: cmd_hold is high from the deep power-down entry pulse until re-initialization completes. In deep power-down, txn_valid produces no pulse and no exit.
- R10: Priority is deep power-down, then self-refresh, then power-down. In power-down, sr_req=1 or dpd_en=1 forces an exit. In self-refresh, dpd_en=1 forces an exit. At most one of mode_pd, mode_sr and mode_dpd is high at any time.
- R11: enter_pulse and exit_pulse last exactly one cycle, and pulse_mode is 2'b00 when neither is high. A mode flag rises in the cycle after cmd_done is sampled following the entry pulse. It falls in the cycle after cmd_done is sampled following the exit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_en | input | 1 | Power-down enable |
| sr_req | input | 1 | Self-refresh request |
| dpd_en | input | 1 | Deep power-down enable |
| pd_idle_x32 | input | TW | Power-down idle timeout in units of 32 cycles |
| dpd_wait_x1024 | input | TW | Deep power-down exit wait in units of 1024 cycles |
| buf_empty | input | 1 | Transaction buffers are empty |
| txn_valid | input | 1 | A transaction arrives this cycle |
| ref_req | input | 1 | Refresh request strobe |
| cmd_done | input | 1 | Scheduler acknowledge of the last entry or exit command |
| init_done | input | 1 | DRAM re-initialization finished |
| enter_pulse | output | 1 | One-cycle low-power entry command |
| exit_pulse | output | 1 | One-cycle low-power exit command |
| pulse_mode | output | 2 | Mode of the current pulse: 01 power-down, 10 self-refresh, 11 deep power-down |
| init_req | output | 1 | Re-initialization request |
| mode_pd | output | 1 | Device is in power-down |
| mode_sr | output | 1 | Device is in self-refresh |
| mode_dpd | output | 1 | Device is in deep power-down |
| cmd_hold | output | 1 | Hold incoming commands during the deep power-down sequence |

## Verification
Every result of the block is registered once after the input that causes it is sampled. An entry pulse appears in the cycle after the triggering condition, or after the N-th idle cycle. A mode flag changes in the cycle after cmd_done. The deep power-down exit pulse appears in the cycle after the last cycle of the wait window, and init_req rises in the cycle after the exit is acknowledged. The bench's behavioural model advances on the same rising edge as the design and is compared on the falling edge, so each expected value is checked in the cycle it becomes due. The directed checks sample a few cycles after the scheduler and init responders have had time to answer.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [4:0] {
    S_ACT,
    S_PD_EP, S_PD_EW, S_PD, S_PD_XP, S_PD_XW,
    S_SR_EP, S_SR_EW, S_SR, S_SR_XP, S_SR_XW,
    S_DP_EP, S_DP_EW, S_DP, S_DP_TM, S_DP_XP, S_DP_XW,
    S_INIT
  } lpm_state_e;

  typedef enum logic [1:0] {
    M_NONE = 2'b00,
    M_PD   = 2'b01,
    M_SR   = 2'b10,
    M_DP   = 2'b11
  } lpm_mode_e;

endpackage

// File: rtl/lpm_req_arb.sv
module lpm_req_arb (
  input  logic pd_en,
  input  logic sr_req,
  input  logic dpd_en,
  input  logic buf_empty,
  input  logic txn_valid,
  input  logic ref_req,
  output logic pd_idle,
  output logic sr_go,
  output logic dp_go,
  output logic pd_leave,
  output logic sr_leave,
  output logic dp_leave
);

  logic quiet;

  always_comb begin
    quiet    = buf_empty & ~txn_valid;
    dp_go    = dpd_en & quiet;
    sr_go    = sr_req & quiet & ~dp_go;
    pd_idle  = pd_en & quiet & ~ref_req;
    // higher-priority requests also pull the device out of a lower mode
    pd_leave = txn_valid | ref_req | ~pd_en | sr_req | dpd_en;
    sr_leave = txn_valid | dpd_en;
    dp_leave = ~dpd_en;
  end

endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] thr,
  output logic          hit
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run | (cnt_q != '0);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
    hit    = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, thr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_idle,
  input  logic       sr_go,
  input  logic       dp_go,
  input  logic       pd_leave,
  input  logic       sr_leave,
  input  logic       dp_leave,
  input  logic       tmr_hit,
  input  logic       cmd_done,
  input  logic       init_done,
  output logic       tmr_run,
  output logic       tmr_sel,
  output logic       enter_pulse,
  output logic       exit_pulse,
  output logic [1:0] pulse_mode,
  output logic       mode_pd,
  output logic       mode_sr,
  output logic       mode_dpd,
  output logic       init_req,
  output logic       cmd_hold
);

  lpm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_ACT: begin
        if (dp_go)                  st_d = S_DP_EP;
        else if (sr_go)             st_d = S_SR_EP;
        else if (pd_idle & tmr_hit) st_d = S_PD_EP;
      end
      S_PD_EP: st_d = S_PD_EW;
      S_PD_EW: if (cmd_done) st_d = S_PD;
      S_PD:    if (pd_leave) st_d = S_PD_XP;
      S_PD_XP: st_d = S_PD_XW;
      S_PD_XW: if (cmd_done) st_d = S_ACT;
      S_SR_EP: st_d = S_SR_EW;
      S_SR_EW: if (cmd_done) st_d = S_SR;
      S_SR:    if (sr_leave) st_d = S_SR_XP;
      S_SR_XP: st_d = S_SR_XW;
      S_SR_XW: if (cmd_done) st_d = S_ACT;
      S_DP_EP: st_d = S_DP_EW;
      S_DP_EW: if (cmd_done) st_d = S_DP;
      S_DP:    if (dp_leave) st_d = S_DP_TM;
      S_DP_TM: if (tmr_hit) st_d = S_DP_XP;
      S_DP_XP: st_d = S_DP_XW;
      S_DP_XW: if (cmd_done) st_d = S_INIT;
      S_INIT:  if (init_done) st_d = S_ACT;
      default: st_d = S_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_ACT;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    tmr_sel     = (st_q == S_DP_TM);
    tmr_run     = ((st_q == S_ACT) & pd_idle) | tmr_sel;
    enter_pulse = (st_q == S_PD_EP) | (st_q == S_SR_EP) | (st_q == S_DP_EP);
    exit_pulse  = (st_q == S_PD_XP) | (st_q == S_SR_XP) | (st_q == S_DP_XP);
    unique case (st_q)
      S_PD_EP, S_PD_XP: pulse_mode = M_PD;
      S_SR_EP, S_SR_XP: pulse_mode = M_SR;
      S_DP_EP, S_DP_XP: pulse_mode = M_DP;
      default:          pulse_mode = M_NONE;
    endcase
    mode_pd  = (st_q == S_PD) | (st_q == S_PD_XP) | (st_q == S_PD_XW);
    mode_sr  = (st_q == S_SR) | (st_q == S_SR_XP) | (st_q == S_SR_XW);
    mode_dpd = (st_q == S_DP) | (st_q == S_DP_TM) | (st_q == S_DP_XP) |
               (st_q == S_DP_XW);
    init_req = (st_q == S_INIT);
    cmd_hold = mode_dpd | init_req | (st_q == S_DP_EP) | (st_q == S_DP_EW);
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_en,
  input  logic          sr_req,
  input  logic          dpd_en,
  input  logic [TW-1:0] pd_idle_x32,
  input  logic [TW-1:0] dpd_wait_x1024,
  input  logic          buf_empty,
  input  logic          txn_valid,
  input  logic          ref_req,
  input  logic          cmd_done,
  input  logic          init_done,
  output logic          enter_pulse,
  output logic          exit_pulse,
  output logic [1:0]    pulse_mode,
  output logic          init_req,
  output logic          mode_pd,
  output logic          mode_sr,
  output logic          mode_dpd,
  output logic          cmd_hold
);

  localparam int PD_SH = 5;
  localparam int DP_SH = 10;
  localparam int CW    = TW + DP_SH;

  logic pd_idle, sr_go, dp_go, pd_leave, sr_leave, dp_leave;
  logic tmr_run, tmr_sel, tmr_hit;
  logic [CW-1:0] pd_thr, dp_thr, thr;

  always_comb begin
    pd_thr = {{(DP_SH - PD_SH){1'b0}}, pd_idle_x32, {PD_SH{1'b0}}};
    dp_thr = {dpd_wait_x1024, {DP_SH{1'b0}}};
    thr    = tmr_sel ? dp_thr : pd_thr;
  end

  lpm_req_arb arb_i (
    .pd_en     (pd_en),
    .sr_req    (sr_req),
    .dpd_en    (dpd_en),
    .buf_empty (buf_empty),
    .txn_valid (txn_valid),
    .ref_req   (ref_req),
    .pd_idle   (pd_idle),
    .sr_go     (sr_go),
    .dp_go     (dp_go),
    .pd_leave  (pd_leave),
    .sr_leave  (sr_leave),
    .dp_leave  (dp_leave)
  );

  lpm_timer #(.CW(CW)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .thr   (thr),
    .hit   (tmr_hit)
  );

  lpm_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_idle     (pd_idle),
    .sr_go       (sr_go),
    .dp_go       (dp_go),
    .pd_leave    (pd_leave),
    .sr_leave    (sr_leave),
    .dp_leave    (dp_leave),
    .tmr_hit     (tmr_hit),
    .cmd_done    (cmd_done),
    .init_done   (init_done),
    .tmr_run     (tmr_run),
    .tmr_sel     (tmr_sel),
    .enter_pulse (enter_pulse),
    .exit_pulse  (exit_pulse),
    .pulse_mode  (pulse_mode),
    .mode_pd     (mode_pd),
    .mode_sr     (mode_sr),
    .mode_dpd    (mode_dpd),
    .init_req    (init_req),
    .cmd_hold    (cmd_hold)
  );

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_valid,
  input logic       cmd_done,
  input logic       init_done,
  input logic       enter_pulse,
  input logic       exit_pulse,
  input logic [1:0] pulse_mode,
  input logic       init_req,
  input logic       mode_pd,
  input logic       mode_sr,
  input logic       mode_dpd,
  input logic       cmd_hold
);

  // R11
  enter_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |=> !enter_pulse);

  // R11
  exit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse);

  // R11
  mode_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_pulse || exit_pulse) |-> (pulse_mode == 2'b00));

  // R10
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_pd, mode_sr, mode_dpd}));

  // R10
  enter_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pulse |-> !(mode_pd || mode_sr || mode_dpd || init_req));

  // R11
  pd_rise_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_pd) |-> $past(cmd_done));

  // R11
  sr_rise_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_sr) |-> $past(cmd_done));

  // R8
  init_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !init_done) |=> init_req);

  // R9
  hold_in_dpd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dpd || init_req) |-> cmd_hold);

  // R9
  dpd_ignores_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dpd && !exit_pulse && txn_valid) |=> mode_dpd);

endmodule

bind lpm_seq lpm_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .txn_valid   (txn_valid),
  .cmd_done    (cmd_done),
  .init_done   (init_done),
  .enter_pulse (enter_pulse),
  .exit_pulse  (exit_pulse),
  .pulse_mode  (pulse_mode),
  .init_req    (init_req),
  .mode_pd     (mode_pd),
  .mode_sr     (mode_sr),
  .mode_dpd    (mode_dpd),
  .cmd_hold    (cmd_hold)
);

// File: tb/lpm_seq_tb.sv
module lpm_seq_tb_top;

  localparam int TW      = 6;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 150000;

  logic clk;
  logic rst_n;
  logic pd_en, sr_req, dpd_en;
  logic [TW-1:0] pd_idle_x32, dpd_wait_x1024;
  logic buf_empty, txn_valid, ref_req;
  logic man_done, resp_done, man_init, resp_init;
  logic cmd_done, init_done;
  logic enter_pulse, exit_pulse, init_req, mode_pd, mode_sr, mode_dpd, cmd_hold;
  logic [1:0] pulse_mode;

  assign cmd_done  = man_done | resp_done;
  assign init_done = man_init | resp_init;

  lpm_seq #(.TW(TW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .pd_en          (pd_en),
    .sr_req         (sr_req),
    .dpd_en         (dpd_en),
    .pd_idle_x32    (pd_idle_x32),
    .dpd_wait_x1024 (dpd_wait_x1024),
    .buf_empty      (buf_empty),
    .txn_valid      (txn_valid),
    .ref_req        (ref_req),
    .cmd_done       (cmd_done),
    .init_done      (init_done),
    .enter_pulse    (enter_pulse),
    .exit_pulse     (exit_pulse),
    .pulse_mode     (pulse_mode),
    .init_req       (init_req),
    .mode_pd        (mode_pd),
    .mode_sr        (mode_sr),
    .mode_dpd       (mode_dpd),
    .cmd_hold       (cmd_hold)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done_flag = 0;
  bit auto_ack  = 1;
  bit auto_init = 1;
  int ack_cd  = 0;
  int init_cd = 0;

  // reference model: mode 0 none, 1 power-down, 2 self-refresh, 3 deep
  // stage 0 active, 1 entry pulse, 2 entry wait, 3 in mode,
  // 4 deep exit wait, 5 exit pulse, 6 exit ack wait, 7 re-init
  int m_mode  = 0;
  int m_stage = 0;
  int m_idle  = 0;
  int m_tmr   = 0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done_flag) begin
      errors++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WDOG);
      report();
      $finish;
    end
    if (!rst_n) begin
      m_mode = 0; m_stage = 0; m_idle = 0; m_tmr = 0;
    end else begin
      case (m_stage)
        0: begin
          if (dpd_en && buf_empty && !txn_valid) begin
            m_mode = 3; m_stage = 1; m_idle = 0;
          end else if (sr_req && buf_empty && !txn_valid) begin
            m_mode = 2; m_stage = 1; m_idle = 0;
          end else if (pd_en && buf_empty && !txn_valid && !ref_req) begin
            int lim;
            lim = int'(pd_idle_x32) * 32;
            if (lim < 1) lim = 1;
            m_idle++;
            if (m_idle >= lim) begin
              m_mode = 1; m_stage = 1; m_idle = 0;
            end
          end else begin
            m_idle = 0;
          end
        end
        1: m_stage = 2;
        2: if (cmd_done) m_stage = 3;
        3: begin
          if (m_mode == 1 && (txn_valid || ref_req || !pd_en || sr_req || dpd_en)) m_stage = 5;
          else if (m_mode == 2 && (txn_valid || dpd_en)) m_stage = 5;
          else if (m_mode == 3 && !dpd_en) begin m_stage = 4; m_tmr = 0; end
        end
        4: begin
          int lim;
          lim = int'(dpd_wait_x1024) * 1024;
          if (lim < 1) lim = 1;
          m_tmr++;
          if (m_tmr >= lim) m_stage = 5;
        end
        5: m_stage = 6;
        6: if (cmd_done) begin
          if (m_mode == 3) m_stage = 7;
          else begin m_stage = 0; m_mode = 0; m_idle = 0; end
        end
        7: if (init_done) begin m_stage = 0; m_mode = 0; m_idle = 0; end
        default: m_stage = 0;
      endcase
    end
  end

  // compare against the model and run the scheduler/init responders
  always @(negedge clk) begin
    if (cyc > 0 && !done_flag) begin
      chk("R11", "enter_pulse", int'(enter_pulse), int'(m_stage == 1));
      chk("R11", "exit_pulse",  int'(exit_pulse),  int'(m_stage == 5));
      chk("R11", "pulse_mode",  int'(pulse_mode),
          (m_stage == 1 || m_stage == 5) ? m_mode : 0);
      chk("R10", "mode_pd",  int'(mode_pd),  int'(m_mode == 1 && m_stage >= 3));
      chk("R10", "mode_sr",  int'(mode_sr),  int'(m_mode == 2 && m_stage >= 3));
      chk("R10", "mode_dpd", int'(mode_dpd), int'(m_mode == 3 && m_stage >= 3 && m_stage <= 6));
      chk("R8",  "init_req", int'(init_req), int'(m_stage == 7));
      chk("R9",  "cmd_hold", int'(cmd_hold), int'(m_mode == 3 && m_stage >= 1));
    end
    resp_done = 1'b0;
    if (ack_cd == 1) resp_done = 1'b1;
    if (ack_cd > 0) ack_cd--;
    if (auto_ack && (enter_pulse || exit_pulse)) ack_cd = 3;
    resp_init = 1'b0;
    if (init_cd == 1) resp_init = 1'b1;
    if (init_cd > 0) init_cd--;
    if (auto_init && init_req && init_cd == 0 && !resp_init) init_cd = 3;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_txn();
    @(negedge clk); txn_valid = 1'b1;
    @(negedge clk); txn_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    pd_en = 1'b0; sr_req = 1'b0; dpd_en = 1'b0;
    pd_idle_x32 = '0; dpd_wait_x1024 = '0;
    buf_empty = 1'b1; txn_valid = 1'b0; ref_req = 1'b0;
    man_done = 1'b0; resp_done = 1'b0; man_init = 1'b0; resp_init = 1'b0;
    step(3);
    // R1 reset state
    chk("R1", "enter_pulse", int'(enter_pulse), 0);
    chk("R1", "mode flags", int'({mode_pd, mode_sr, mode_dpd}), 0);
    chk("R1", "init_req/cmd_hold", int'({init_req, cmd_hold}), 0);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R1", "outputs after release", int'({enter_pulse, exit_pulse, mode_pd, cmd_hold}), 0);

    // R2 traffic every 20 cycles keeps a 32-cycle idle timer from expiring
    pd_idle_x32 = 6'd1; pd_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(18); pulse_txn();
    end
    chk("R2", "no entry under traffic", int'(mode_pd), 0);
    step(50);
    chk("R2", "entry after idle period", int'(mode_pd), 1);

    // R3 refresh takes the device out and it returns after the idle period
    @(negedge clk); ref_req = 1'b1;
    @(negedge clk); ref_req = 1'b0;
    step(5);
    chk("R3", "exit on refresh", int'(mode_pd), 0);
    step(50);
    chk("R3", "re-entry after refresh", int'(mode_pd), 1);

    // R4 a transaction takes the device out
    pulse_txn();
    step(5);
    chk("R4", "exit on transaction", int'(mode_pd), 0);
    step(50);
    chk("R4", "re-entry after transaction", int'(mode_pd), 1);

    // R5 clearing the enable forces exit and keeps it out
    @(negedge clk); pd_en = 1'b0;
    step(6);
    chk("R5", "exit on disable", int'(mode_pd), 0);
    step(60);
    chk("R5", "no entry while disabled", int'(mode_pd), 0);

    // R6 self-refresh waits for empty buffers, leaves on a transaction
    @(negedge clk); buf_empty = 1'b0; sr_req = 1'b1;
    step(10);
    chk("R6", "no entry with busy buffers", int'(mode_sr), 0);
    @(negedge clk); buf_empty = 1'b1;
    step(8);
    chk("R6", "entry on empty buffers", int'(mode_sr), 1);
    @(negedge clk); txn_valid = 1'b1; sr_req = 1'b0;
    @(negedge clk); txn_valid = 1'b0;
    step(6);
    chk("R6", "exit on transaction", int'(mode_sr), 0);

    // R7 deep power-down waits for empty buffers
    @(negedge clk); buf_empty = 1'b0; dpd_en = 1'b1;
    step(10);
    chk("R7", "no entry with busy buffers", int'(mode_dpd), 0);
    @(negedge clk); buf_empty = 1'b1;
    step(8);
    chk("R7", "entry on empty buffers", int'(mode_dpd), 1);
    chk("R9", "hold in deep power-down", int'(cmd_hold), 1);

    // R9 a transaction during deep power-down is held, no exit
    pulse_txn();
    step(5);
    chk("R9", "txn ignored in deep mode", int'(mode_dpd), 1);
    chk("R9", "hold kept", int'(cmd_hold), 1);

    // R8 exit wait of 1024 cycles, then init request until init_done
    auto_init = 0;
    @(negedge clk); dpd_wait_x1024 = 6'd1; dpd_en = 1'b0;
    step(500);
    chk("R8", "still in wait window", int'(mode_dpd), 1);
    step(600);
    chk("R8", "init requested after exit", int'(init_req), 1);
    chk("R9", "hold during init", int'(cmd_hold), 1);
    @(negedge clk); man_init = 1'b1;
    @(negedge clk); man_init = 1'b0;
    step(1);
    chk("R8", "init request dropped", int'(init_req), 0);
    chk("R9", "hold released", int'(cmd_hold), 0);
    auto_init = 1;

    // R10 all three requested: deep wins, then self-refresh, then power-down
    @(negedge clk); dpd_wait_x1024 = '0; pd_en = 1'b1; sr_req = 1'b1; dpd_en = 1'b1;
    step(8);
    chk("R10", "deep mode wins", int'({mode_dpd, mode_sr, mode_pd}), 4);
    @(negedge clk); dpd_en = 1'b0;
    step(25);
    chk("R10", "self-refresh next", int'({mode_dpd, mode_sr, mode_pd}), 2);
    @(negedge clk); txn_valid = 1'b1; sr_req = 1'b0;
    @(negedge clk); txn_valid = 1'b0;
    step(50);
    chk("R10", "power-down last", int'({mode_dpd, mode_sr, mode_pd}), 1);
    @(negedge clk); sr_req = 1'b1;
    step(14);
    chk("R10", "self-refresh pre-empts power-down", int'({mode_dpd, mode_sr, mode_pd}), 2);
    @(negedge clk); txn_valid = 1'b1; sr_req = 1'b0; pd_en = 1'b0;
    @(negedge clk); txn_valid = 1'b0;
    step(10);

    // R11 status waits for the scheduler acknowledge
    auto_ack = 0;
    @(negedge clk); pd_idle_x32 = '0; pd_en = 1'b1;
    step(10);
    chk("R11", "no flag before done", int'(mode_pd), 0);
    chk("R11", "pulse lasted one cycle", int'(enter_pulse), 0);
    man_done = 1'b1;
    @(negedge clk); man_done = 1'b0;
    chk("R11", "flag one cycle after done", int'(mode_pd), 1);
    auto_ack = 1;
    @(negedge clk); pd_en = 1'b0;
    step(10);
    chk("R11", "flag dropped after exit ack", int'(mode_pd), 0);

    done_flag = 1;
    report();
    $finish;
  end

endmodule